// File: doc/BRIEF.md
# Multiplexed Parallel I/O Port

A twelve-pin bidirectional port in which every pin has its own control bits. A pin can serve as a general-purpose input, as a general-purpose output driven from a software latch, as an output driven by an on-chip peripheral, or as a source for a peripheral's input. Software programs the port through a small word-indexed register bus. The port drives each pad's output value and output enable. It passes synchronized pad levels to the peripheral inputs and raises a masked interrupt when a general-purpose input changes level.

When a peripheral input is not connected to its pin, that input receives a fixed fallback value. The fallback for each pin is set at elaboration time and is either constant low, constant high, or one bit of an auxiliary vector that carries the levels of another port. Every pad level passes through a synchronizer before any logic uses it. Reads of the data word return these synchronized pin levels, not the latch contents.

Top module: `pio_mux_port`

## Requirements
- R1: After reset the assignment, direction, option, latch, edge-mode, event and mask registers are all zero, every `pad_oe` bit is 0 and `irq` is 0.
- R2: The registers sit at word indices 0 (assignment), 1 (direction), 2 (option), 3 (data), 4 (edge mode), 5 (event), 6 (mask); word index *k* corresponds to byte offset 2*k*. Index 7 reads as zero, and bits 15..12 of every read are zero.
- R3: A write to index 3 always updates the output latch. A pin drives its latch value onto the pad, with `pad_oe` = 1, only when its assignment bit is 0, its direction bit is 1 and its option bit is 0. A pin whose direction bit is 0 never drives its pad.
- R4: A read of index 3 returns the synchronized level of every pad, including pads that the port itself drives.
- R5: A pin whose direction bit is 1 and whose assignment or option bit is 1 drives `periph_out` onto the pad, with `pad_oe` = 1.
- R6: `periph_in` of a pin equals its synchronized pad level when the direction bit is 0 and either the assignment bit or the option bit is 1.
- R7: In every other mode, `periph_in` takes the pin's fallback value. With the default parameters: pins 11 and 10 fall back to 1; pins 2, 3, 4 and 5 take `aux_in` bits 13, 12, 15 and 14; all other pins fall back to 0.
- R8: A change on `pad_in` first appears in a data read after the second rising clock edge following the change, not after the first.
- R9: A pin whose assignment and direction bits are both 0 is a general-purpose input, whatever its option bit. When its edge-mode bit is 0, either edge sets its event flag. When the bit is 1, only a falling edge sets the flag.
- R10: Writing 1 to an event bit at index 5 clears that flag, and writing 0 leaves it unchanged. A new event in the same cycle as the clear takes priority and sets the flag.
- R11: `irq` is 1 exactly when some event flag is set and its mask bit is also set.
- R12: A pin that is not a general-purpose input never sets its event flag, even when its pad toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| pad_in | input | 12 | Level seen at each pad |
| pad_out | output | 12 | Value driven onto each pad |
| pad_oe | output | 12 | Output enable per pad |
| periph_out | input | 12 | Peripheral output value per pin |
| periph_in | output | 12 | Peripheral input value per pin |
| aux_in | input | 16 | Levels from another port, used as fallbacks |
| irq | output | 1 | Masked pin-change interrupt |

## Verification
The bench runs fixed mixed configurations across all eight mode combinations of every pin. It models the pad as resolved, which exposes designs that read back the latch in place of the pin, that drive the pad in input modes, or that send the latch out in peripheral-output mode. It varies the auxiliary vector, so a fallback wired to the wrong auxiliary bit or given the wrong constant shows up on `periph_in`. It samples the data word one edge early and then on time, which catches a synchronizer that is one stage too short. The interrupt sweep toggles each pin in both edge modes and checks that a wrong polarity or any-edge bug sets the wrong flag, that writing zeros does not clear flags, and that outputs and peripheral pins never raise events.

// File: rtl/pio_pkg.sv
package pio_pkg;

   // register word indices (byte offset = 2 * index)
   typedef enum logic [2:0] {
      RI_ASG   = 3'd0,
      RI_DIR   = 3'd1,
      RI_SOPT  = 3'd2,
      RI_DATA  = 3'd3,
      RI_IMODE = 3'd4,
      RI_EVT   = 3'd5,
      RI_MASK  = 3'd6
   } reg_idx_e;

   // fallback kinds for peripheral inputs
   localparam logic [1:0] DK_ZERO = 2'd0;
   localparam logic [1:0] DK_ONE  = 2'd1;
   localparam logic [1:0] DK_AUX  = 2'd2;

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
   parameter int W      = 12,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic         settled
);
   localparam int VLD_W = STAGES + 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("pio_sync needs at least two stages");
   end

   logic [W-1:0]     pipe [STAGES];
   logic [VLD_W-1:0] vld;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[0] <= '0;
            else        pipe[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= '0;
            else        pipe[s] <= pipe[s-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld <= '0;
      else        vld <= {vld[VLD_W-2:0], 1'b1};
   end

   assign q       = pipe[STAGES-1];
   assign settled = vld[VLD_W-1];

   // R8
   sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      settled |=> (q == $past(pipe[STAGES-2])));

endmodule

// File: rtl/pio_regs.sv
module pio_regs
   import pio_pkg::*;
#(
   parameter int NPINS  = 12,
   parameter int DATA_W = 16,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NPINS-1:0]  pin_lvl,
   input  logic [NPINS-1:0]  flags,
   output logic [NPINS-1:0]  asg_q,
   output logic [NPINS-1:0]  dir_q,
   output logic [NPINS-1:0]  sopt_q,
   output logic [NPINS-1:0]  latch_q,
   output logic [NPINS-1:0]  imode_q,
   output logic [NPINS-1:0]  mask_q,
   output logic [NPINS-1:0]  evt_w1c
);
   localparam int PAD_W = DATA_W - NPINS;

   if (NPINS > DATA_W) begin : g_bad_width
      $error("pio_regs: more pins than data bits");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("pio_regs: address must hold seven indices");
   end

   logic [NPINS-1:0] wd;
   logic             hit_asg, hit_dir, hit_sopt, hit_data, hit_imode, hit_evt, hit_mask;
   logic             unused_wdata;

   assign wd           = bus_wdata[NPINS-1:0];
   assign unused_wdata = ^bus_wdata;

   assign hit_asg   = bus_wr && (bus_addr == ADDR_W'(RI_ASG));
   assign hit_dir   = bus_wr && (bus_addr == ADDR_W'(RI_DIR));
   assign hit_sopt  = bus_wr && (bus_addr == ADDR_W'(RI_SOPT));
   assign hit_data  = bus_wr && (bus_addr == ADDR_W'(RI_DATA));
   assign hit_imode = bus_wr && (bus_addr == ADDR_W'(RI_IMODE));
   assign hit_evt   = bus_wr && (bus_addr == ADDR_W'(RI_EVT));
   assign hit_mask  = bus_wr && (bus_addr == ADDR_W'(RI_MASK));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         asg_q   <= '0;
         dir_q   <= '0;
         sopt_q  <= '0;
         latch_q <= '0;
         imode_q <= '0;
         mask_q  <= '0;
      end else begin
         if (hit_asg)   asg_q   <= wd;
         if (hit_dir)   dir_q   <= wd;
         if (hit_sopt)  sopt_q  <= wd;
         if (hit_data)  latch_q <= wd;
         if (hit_imode) imode_q <= wd;
         if (hit_mask)  mask_q  <= wd;
      end
   end

   assign evt_w1c = hit_evt ? wd : '0;

   logic [NPINS-1:0] rd_sel;
   always_comb begin
      case (bus_addr)
         ADDR_W'(RI_ASG):   rd_sel = asg_q;
         ADDR_W'(RI_DIR):   rd_sel = dir_q;
         ADDR_W'(RI_SOPT):  rd_sel = sopt_q;
         ADDR_W'(RI_DATA):  rd_sel = pin_lvl;
         ADDR_W'(RI_IMODE): rd_sel = imode_q;
         ADDR_W'(RI_EVT):   rd_sel = flags;
         ADDR_W'(RI_MASK):  rd_sel = mask_q;
         default:           rd_sel = '0;
      endcase
   end

   if (PAD_W > 0) begin : g_pad
      assign bus_rdata = {{PAD_W{1'b0}}, rd_sel};
   end else begin : g_nopad
      assign bus_rdata = rd_sel;
   end

   // R2
   asg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_asg |=> $stable(asg_q));

   // R3
   latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_data |=> (latch_q == $past(wd)));

endmodule

// File: rtl/pio_pin_cell.sv
module pio_pin_cell
   import pio_pkg::*;
#(
   parameter logic [1:0] DFLT_KIND = DK_ZERO,
   parameter int         AUX_W     = 16,
   parameter int         AUX_IDX   = 0
) (
   input  logic             asg,
   input  logic             dir,
   input  logic             sopt,
   input  logic             latch,
   input  logic             lvl,
   input  logic             periph_o,
   input  logic [AUX_W-1:0] aux_in,
   output logic             pad_o,
   output logic             pad_oe,
   output logic             periph_i
);
   if (AUX_IDX < 0 || AUX_IDX >= AUX_W) begin : g_bad_idx
      $error("pio_pin_cell: auxiliary index out of range");
   end
   if (DFLT_KIND == 2'd3) begin : g_bad_kind
      $error("pio_pin_cell: unknown fallback kind");
   end

   logic dflt;
   logic unused_aux;

   if (DFLT_KIND == DK_ONE) begin : g_one
      assign dflt       = 1'b1;
      assign unused_aux = ^aux_in;
   end else if (DFLT_KIND == DK_AUX) begin : g_aux
      assign dflt       = aux_in[AUX_IDX];
      assign unused_aux = ^aux_in;
   end else begin : g_zero
      assign dflt       = 1'b0;
      assign unused_aux = ^aux_in;
   end

   logic ded_sel;   // dedicated role: assignment or option picks the peripheral
   logic routed;

   assign ded_sel  = asg | sopt;
   assign pad_oe   = dir;
   assign pad_o    = ded_sel ? periph_o : latch;
   assign routed   = ~dir & ded_sel;
   assign periph_i = routed ? lvl : dflt;

endmodule

// File: rtl/pio_irq.sv
module pio_irq #(
   parameter int NPINS = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] lvl,
   input  logic             settled,
   input  logic [NPINS-1:0] gp_in,
   input  logic [NPINS-1:0] imode,
   input  logic [NPINS-1:0] w1c,
   input  logic [NPINS-1:0] mask,
   output logic [NPINS-1:0] flags,
   output logic             irq
);
   logic [NPINS-1:0] prev;
   logic [NPINS-1:0] ev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= lvl;
   end

   for (genvar i = 0; i < NPINS; i++) begin : g_det
      logic fall_e, rise_e;
      assign fall_e = prev[i] & ~lvl[i];
      assign rise_e = ~prev[i] & lvl[i];
      assign ev[i]  = settled & gp_in[i] & (fall_e | (rise_e & ~imode[i]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= (flags & ~w1c) | ev;
   end

   assign irq = |(flags & mask);

   // R12
   no_flag_nongp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flags & ~$past(flags) & ~$past(gp_in)) == '0));

   // R10
   clear_only_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((~flags & $past(flags) & ~$past(w1c)) == '0));

   // R9
   fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flags & ~$past(flags) & $past(imode) & $past(lvl)) == '0));

   // R11
   irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (mask != '0));

endmodule

// File: rtl/pio_mux_port.sv
module pio_mux_port
   import pio_pkg::*;
#(
   parameter int                  NPINS       = 12,
   parameter int                  DATA_W      = 16,
   parameter int                  ADDR_W      = 3,
   parameter int                  SYNC_STAGES = 2,
   parameter int                  AUX_W       = 16,
   parameter logic [2*NPINS-1:0]  DFLT_KIND   = 24'h500AA0,
   parameter logic [8*NPINS-1:0]  DFLT_AIDX   = 96'h0000_0000_0000_0E0F_0C0D_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_oe,
   input  logic [NPINS-1:0]  periph_out,
   output logic [NPINS-1:0]  periph_in,
   input  logic [AUX_W-1:0]  aux_in,
   output logic              irq
);
   logic [NPINS-1:0] asg_q, dir_q, sopt_q, latch_q, imode_q, mask_q;
   logic [NPINS-1:0] evt_w1c, flags, lvl, gp_in;
   logic             settled;

   pio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) sync_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .d       (pad_in),
      .q       (lvl),
      .settled (settled)
   );

   pio_regs #(.NPINS(NPINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_lvl   (lvl),
      .flags     (flags),
      .asg_q     (asg_q),
      .dir_q     (dir_q),
      .sopt_q    (sopt_q),
      .latch_q   (latch_q),
      .imode_q   (imode_q),
      .mask_q    (mask_q),
      .evt_w1c   (evt_w1c)
   );

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      localparam logic [1:0] KIND = DFLT_KIND[2*i +: 2];
      localparam int         AIDX = int'(DFLT_AIDX[8*i +: 8]);
      pio_pin_cell #(.DFLT_KIND(KIND), .AUX_W(AUX_W), .AUX_IDX(AIDX)) cell_i (
         .asg      (asg_q[i]),
         .dir      (dir_q[i]),
         .sopt     (sopt_q[i]),
         .latch    (latch_q[i]),
         .lvl      (lvl[i]),
         .periph_o (periph_out[i]),
         .aux_in   (aux_in),
         .pad_o    (pad_out[i]),
         .pad_oe   (pad_oe[i]),
         .periph_i (periph_in[i])
      );
   end

   assign gp_in = ~asg_q & ~dir_q;

   pio_irq #(.NPINS(NPINS)) irq_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl     (lvl),
      .settled (settled),
      .gp_in   (gp_in),
      .imode   (imode_q),
      .w1c     (evt_w1c),
      .mask    (mask_q),
      .flags   (flags),
      .irq     (irq)
   );

   // R1
   reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pad_oe == '0 && !irq));

   // R3
   input_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & ~dir_q) == '0);

   // R6
   routed_follows_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((periph_in ^ lvl) & ~dir_q & (asg_q | sopt_q)) == '0);

endmodule

// File: tb/pio_mux_port_tb_top.sv
module pio_mux_port_tb_top;
   localparam int                 N    = 12;
   localparam logic [2*N-1:0]     KIND = 24'h500AA0;
   localparam logic [8*N-1:0]     AIDX = 96'h0000_0000_0000_0E0F_0C0D_0000;
   localparam logic [N-1:0]       ALL  = 12'hFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [N-1:0] pad_in, pad_out, pad_oe, periph_in;
   logic [N-1:0] periph_out = '0;
   logic [N-1:0] ext = '0;
   logic [15:0] aux_in = '0;
   logic        irq;
   int          nchk = 0;
   int          nfail = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

   pio_mux_port #(.DFLT_KIND(KIND), .DFLT_AIDX(AIDX)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .periph_out(periph_out),
      .periph_in(periph_in), .aux_in(aux_in), .irq(irq)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   function automatic logic fb(input int i, input logic [15:0] aux);
      logic [1:0] k = KIND[2*i +: 2];
      int         x = int'(AIDX[8*i +: 8]);
      if (k == 2'd1) return 1'b1;
      if (k == 2'd2) return aux[x];
      return 1'b0;
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog expired act=running exp=finished");
      finish_run();
   end

   initial begin
      logic [15:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 pad_oe", {4'h0, pad_oe}, 16'h0);
      chk("R1 irq", {15'h0, irq}, 16'h0);
      for (int a = 0; a < 7; a++) begin
         rd(3'(a), r);
         chk($sformatf("R1 reg %0d", a), r, 16'h0);
      end
      // R2 upper bits and unused index
      wr(3'd0, 16'hFFFF); rd(3'd0, r); chk("R2 asg width", r, 16'h0FFF);
      wr(3'd6, 16'hFA5A); rd(3'd6, r); chk("R2 mask width", r, 16'h0A5A);
      rd(3'd7, r); chk("R2 index7", r, 16'h0);
      wr(3'd0, 16'h0); wr(3'd6, 16'h0);

      // R3 R4 R5 R6 R7 mode sweep
      for (int t = 0; t < 24; t++) begin
         logic [N-1:0] a, d, s, l, eo, ep, ev, pl;
         a = N'(12'hA5C ^ (t * 12'h1D3));
         d = N'(12'h3C6 ^ (t * 12'h2B5));
         s = N'(12'h7E1 ^ (t * 12'h0F9));
         l = N'(12'h539 ^ (t * 12'h6A7));
         wr(3'd0, {4'h0, a}); wr(3'd1, {4'h0, d});
         wr(3'd2, {4'h0, s}); wr(3'd3, {4'h0, l});
         @(negedge clk);
         ext = N'(12'h96D ^ (t * 12'h3E5));
         periph_out = N'(12'h2F4 ^ (t * 12'h1B7));
         aux_in = 16'hC3A5 ^ 16'(t * 16'h4E1B);
         settle();
         eo = d;
         for (int i = 0; i < N; i++)
            ev[i] = (a[i] | s[i]) ? periph_out[i] : l[i];
         pl = (eo & ev) | (~eo & ext);
         for (int i = 0; i < N; i++)
            ep[i] = (!d[i] && (a[i] || s[i])) ? pl[i] : fb(i, aux_in);
         chk($sformatf("R3 pad_oe t%0d", t), {4'h0, pad_oe}, {4'h0, eo});
         chk($sformatf("R5 pad_out t%0d", t), {4'h0, pad_out & pad_oe}, {4'h0, ev & eo});
         chk($sformatf("R6 R7 periph_in t%0d", t), {4'h0, periph_in}, {4'h0, ep});
         rd(3'd3, r);
         chk($sformatf("R4 data read t%0d", t), r, {4'h0, pl});
      end

      // R8 two-edge latency, all pins GP inputs
      wr(3'd0, 16'h0); wr(3'd1, 16'h0); wr(3'd2, 16'h0);
      ext = 12'h0; settle();
      @(negedge clk); bus_addr = 3'd3; ext = 12'hB6D;
      @(negedge clk); #1 chk("R8 one edge", bus_rdata, 16'h0);
      @(negedge clk); #1 chk("R8 two edges", bus_rdata, 16'h0B6D);
      ext = 12'h0; settle();

      // R9 R10 R11 edge modes per pin
      wr(3'd2, 16'h0A0A);  // option bit set on some GP inputs: still GP
      wr(3'd5, 16'h0FFF); settle();
      for (int i = 0; i < N; i++) begin
         for (int md = 0; md < 2; md++) begin
            logic [N-1:0] b = N'(1) << i;
            wr(3'd4, md ? 16'h0FFF : 16'h0);
            wr(3'd6, {4'h0, ~b});
            wr(3'd5, 16'h0FFF);
            @(negedge clk); ext = b; settle();
            rd(3'd5, r);
            chk($sformatf("R9 rise pin%0d mode%0d", i, md), r, md ? 16'h0 : {4'h0, b});
            wr(3'd5, 16'h0FFF);
            @(negedge clk); ext = '0; settle();
            rd(3'd5, r);
            chk($sformatf("R9 fall pin%0d mode%0d", i, md), r, {4'h0, b});
            chk($sformatf("R11 masked pin%0d", i), {15'h0, irq}, 16'h0);
            wr(3'd6, 16'h0FFF);
            @(negedge clk);
            chk($sformatf("R11 unmasked pin%0d", i), {15'h0, irq}, 16'h1);
            wr(3'd5, {4'h0, ~b}); rd(3'd5, r);
            chk($sformatf("R10 other bits pin%0d", i), r, {4'h0, b});
            wr(3'd5, 16'h0); rd(3'd5, r);
            chk($sformatf("R10 zero write pin%0d", i), r, {4'h0, b});
            wr(3'd5, {4'h0, b}); rd(3'd5, r);
            chk($sformatf("R10 clear pin%0d", i), r, 16'h0);
         end
      end

      // R12 peripheral inputs and outputs raise no events
      wr(3'd4, 16'h0); wr(3'd2, 16'h0);
      wr(3'd0, 16'h0FFF); settle(); wr(3'd5, 16'h0FFF);
      @(negedge clk); ext = 12'hFFF; settle();
      @(negedge clk); ext = 12'h000; settle();
      rd(3'd5, r); chk("R12 peripheral input toggles", r, 16'h0);
      wr(3'd0, 16'h0); wr(3'd1, 16'h0FFF); wr(3'd3, 16'h0); settle();
      wr(3'd5, 16'h0FFF);
      wr(3'd3, 16'h0FFF); settle();
      wr(3'd3, 16'h0000); settle();
      rd(3'd5, r); chk("R12 output toggles", r, 16'h0);
      rd(3'd3, r); chk("R4 output pins read low", r, 16'h0);
      wr(3'd0, 16'h0FFF); wr(3'd5, 16'h0FFF);
      periph_out = 12'hFFF; settle();
      periph_out = 12'h000; settle();
      rd(3'd5, r); chk("R12 peripheral output toggles", r, 16'h0);
      chk("R11 irq idle", {15'h0, irq}, 16'h0);

      finish_run();
   end
endmodule